// File: doc/BRIEF.md
# PHY and PLL Power-Mode Handshake Controller

This block keeps the requested power modes of two analog domains, a display PHY and its PLL, in one small control register. Each domain also reports the mode it has actually reached. Software writes a 2-bit mode request for each domain. After a settling time, the block moves that domain's observed-mode field to the requested value. Reading the register returns both requests and both observed modes, so a driver can poll until they match.

The analog macros are not modelled. Each domain has its own settle counter, whose length in cycles is a parameter. A hold input per domain stands in for a macro that never acknowledges. While hold is high, the domain's settle counter stops counting.

A second counter in each domain measures how long the current transition has been waiting. When that wait reaches a timeout parameter, the domain raises a sticky timeout flag. Software clears the flag by writing 1 to its bit.

Top module: `pwrhs_ctrl`

## Requirements
- R1: While reset is active, and on the first read after it, every field of `reg_rdata` is 0. This means both requests and both observed modes are 00 and neither timeout flag is set.
- R2: Register layout of `reg_rdata`:
  - bits 7:6 hold the PHY request and bits 5:4 the PHY observed mode;
  - bits 3:2 hold the PLL request and bits 1:0 the PLL observed mode;
  - bit 8 is the PHY timeout flag and bit 9 the PLL timeout flag.

  A write updates both request fields. Bits 5:4 and 1:0 of `reg_wdata` are ignored.
- R3: A request written at clock edge E can be read back after edge E.
- R4: A transition starts at edge E. With no hold, the observed mode takes the requested value at edge E+PHY_SETTLE_CYC for the PHY and at edge E+PLL_SETTLE_CYC for the PLL. Whenever a domain is idle, its observed mode equals its request.
- R5: Writing a request equal to the domain's observed mode starts no transition. It also cancels a pending one, so the observed mode stays as it is.
- R6: Writing a different request while a transition is pending restarts that domain's settle time from the new write.
- R7: Rewriting the pending request unchanged does not restart the settle time.
- R8: While a domain's `hold_i` bit is high, its observed mode does not change and its settle count is frozen. After release, the remaining settle cycles elapse, and the other domain is unaffected.
- R9: If a transition is still unfinished TIMEOUT_CYC edges after it started, the domain's flag is set at edge E+TIMEOUT_CYC. The flag stays set until it is cleared and is not set again for the same transition. TIMEOUT_CYC must exceed both settle lengths.
- R10: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. If a clear and a set fall on the same edge, the set wins.
- R11: An observed mode changes only to the request that was current in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 10 | Write data (request fields, flag clear bits) |
| hold_i | input | 2 | Per-domain stall injection, bit 0 PHY, bit 1 PLL |
| reg_rdata | output | 10 | Register read value |

## Verification
The bench builds the block with a PHY settle time of 4 cycles, a PLL settle time of 7 cycles and a timeout of 20 cycles. With these short windows the bench can count exact change edges for both domains. The different settle lengths show that the two domains are independent. A held transition can cross the timeout edge within a few dozen cycles, and that edge can be hit precisely with a simultaneous clear to test which one wins.

// File: rtl/pwrhs_pkg.sv
package pwrhs_pkg;

    localparam int NDOM     = 2;
    localparam int DOM_PHY  = 0;
    localparam int DOM_PLL  = 1;
    localparam int MODE_W   = 2;
    localparam int SLOT_W   = 2 * MODE_W;
    localparam int FLAG_LSB = NDOM * SLOT_W;
    localparam int REG_W    = FLAG_LSB + NDOM;

    typedef logic [MODE_W-1:0] pmode_t;

    // Domain 0 sits in the upper nibble, domain 1 in the lower nibble.
    function automatic int req_lsb(input int dom);
        return (NDOM - 1 - dom) * SLOT_W + MODE_W;
    endfunction

    function automatic int obs_lsb(input int dom);
        return (NDOM - 1 - dom) * SLOT_W;
    endfunction

    function automatic int flag_bit(input int dom);
        return FLAG_LSB + dom;
    endfunction

endpackage

// File: rtl/pwrhs_wdecode.sv
module pwrhs_wdecode
    import pwrhs_pkg::*;
(
    input  logic                          wr_en,
    input  logic [REG_W-1:0]              wr_data,
    output logic [NDOM-1:0]               req_we,
    output logic [NDOM-1:0][MODE_W-1:0]   req_val,
    output logic [NDOM-1:0]               flag_clr
);

    logic ro_fields_unused;
    logic [NDOM-1:0] ro_bits;

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        localparam int RL = req_lsb(g);
        localparam int OL = obs_lsb(g);
        localparam int FB = flag_bit(g);

        always_comb begin
            req_we[g]   = wr_en;
            req_val[g]  = wr_data[RL +: MODE_W];
            flag_clr[g] = wr_en & wr_data[FB];
            ro_bits[g]  = ^wr_data[OL +: MODE_W];
        end
    end

    // Observed-mode bits carry no write meaning.
    assign ro_fields_unused = ^ro_bits;

endmodule

// File: rtl/pwrhs_domain.sv
module pwrhs_domain
    import pwrhs_pkg::*;
#(
    parameter int SETTLE_CYC  = 24,
    parameter int TIMEOUT_CYC = 200
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_we,
    input  pmode_t req_val,
    input  logic   flag_clr,
    input  logic   hold_i,
    output pmode_t req_o,
    output pmode_t obs_o,
    output logic   flag_o
);

    localparam int LIM = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
    localparam int CW  = $clog2(LIM + 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] TOUT_LAST   = CW'(TIMEOUT_CYC - 1);
    localparam logic [CW-1:0] TOUT_FULL   = CW'(TIMEOUT_CYC);

    typedef struct packed {
        pmode_t          req;
        pmode_t          obs;
        logic            busy;
        logic            flag;
        logic [CW-1:0]   scnt;
        logic [CW-1:0]   wcnt;
    } dom_s;

    dom_s dom_d, dom_q;

    always_comb begin
        dom_d = dom_q;

        // Settle progress; frozen while the stall input is high.
        if (dom_q.busy && !hold_i) begin
            if (dom_q.scnt == SETTLE_LAST) begin
                dom_d.obs  = dom_q.req;
                dom_d.busy = 1'b0;
                dom_d.scnt = '0;
                dom_d.wcnt = '0;
            end else begin
                dom_d.scnt = dom_q.scnt + 1'b1;
            end
        end

        // Software clear first so a same-edge set overrides it.
        if (flag_clr) begin
            dom_d.flag = 1'b0;
        end

        // Wait measurement saturates, so the flag fires once per transition.
        if (dom_q.busy && dom_q.wcnt != TOUT_FULL) begin
            if (dom_d.busy) begin
                dom_d.wcnt = dom_q.wcnt + 1'b1;
            end
            if (dom_q.wcnt == TOUT_LAST) begin
                dom_d.flag = 1'b1;
            end
        end

        // Request write, compared with the mode this edge leaves behind.
        if (req_we) begin
            dom_d.req = req_val;
            if (req_val == dom_d.obs) begin
                dom_d.busy = 1'b0;
                dom_d.scnt = '0;
                dom_d.wcnt = '0;
            end else if (req_val != dom_q.req || !dom_d.busy) begin
                dom_d.busy = 1'b1;
                dom_d.scnt = '0;
                dom_d.wcnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_q <= '0;
        end else begin
            dom_q <= dom_d;
        end
    end

    assign req_o  = dom_q.req;
    assign obs_o  = dom_q.obs;
    assign flag_o = dom_q.flag;

    AST_IDLE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_q.busy |-> dom_q.obs == dom_q.req);                               // R4

    AST_OBS_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dom_q.obs) |-> dom_q.obs == $past(dom_q.req));                // R11

    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        dom_q.busy && hold_i |=> $stable(dom_q.obs));                          // R8

    AST_FLAG_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dom_q.flag) |-> $past(dom_q.busy));                              // R9

    AST_FLAG_CLEARED_BY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_q.flag) |-> $past(flag_clr));                                // R10

endmodule

// File: rtl/pwrhs_rdpack.sv
module pwrhs_rdpack
    import pwrhs_pkg::*;
(
    input  logic [NDOM-1:0][MODE_W-1:0] req,
    input  logic [NDOM-1:0][MODE_W-1:0] obs,
    input  logic [NDOM-1:0]             flag,
    output logic [REG_W-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        for (int d = 0; d < NDOM; d++) begin
            rdata[req_lsb(d) +: MODE_W] = req[d];
            rdata[obs_lsb(d) +: MODE_W] = obs[d];
            rdata[flag_bit(d)]          = flag[d];
        end
    end

endmodule

// File: rtl/pwrhs_ctrl.sv
module pwrhs_ctrl
    import pwrhs_pkg::*;
#(
    parameter int PHY_SETTLE_CYC = 24,
    parameter int PLL_SETTLE_CYC = 40,
    parameter int TIMEOUT_CYC    = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    input  logic [NDOM-1:0]     hold_i,
    output logic [REG_W-1:0]    reg_rdata
);

    logic [NDOM-1:0]             req_we;
    logic [NDOM-1:0][MODE_W-1:0] req_val;
    logic [NDOM-1:0]             flag_clr;
    logic [NDOM-1:0][MODE_W-1:0] req;
    logic [NDOM-1:0][MODE_W-1:0] obs;
    logic [NDOM-1:0]             flag;

    pwrhs_wdecode u_wdec (
        .wr_en    (reg_we),
        .wr_data  (reg_wdata),
        .req_we   (req_we),
        .req_val  (req_val),
        .flag_clr (flag_clr)
    );

    for (genvar g = 0; g < NDOM; g++) begin : g_dom
        localparam int SC = (g == DOM_PHY) ? PHY_SETTLE_CYC : PLL_SETTLE_CYC;

        pwrhs_domain #(
            .SETTLE_CYC  (SC),
            .TIMEOUT_CYC (TIMEOUT_CYC)
        ) u_dom (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_we   (req_we[g]),
            .req_val  (req_val[g]),
            .flag_clr (flag_clr[g]),
            .hold_i   (hold_i[g]),
            .req_o    (req[g]),
            .obs_o    (obs[g]),
            .flag_o   (flag[g])
        );
    end

    pwrhs_rdpack u_rd (
        .req   (req),
        .obs   (obs),
        .flag  (flag),
        .rdata (reg_rdata)
    );

    AST_REQ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_rdata[7:6] == $past(reg_wdata[7:6])
               && reg_rdata[3:2] == $past(reg_wdata[3:2]));                    // R3

    AST_IDLE_WRITE_KEEPS_OBS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_rdata[7:6] == reg_rdata[5:4] && reg_wdata[7:6] == reg_rdata[5:4]
        |=> $stable(reg_rdata[5:4]));                                          // R5

endmodule

// File: tb/test_pwrhs_ctrl.sv
`timescale 1ns/1ps
module test_pwrhs_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [9:0] reg_wdata = '0;
    logic [1:0] hold_i = '0;
    logic [9:0] reg_rdata;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    pwrhs_ctrl #(
        .PHY_SETTLE_CYC (4),
        .PLL_SETTLE_CYC (7),
        .TIMEOUT_CYC    (20)
    ) i_pwrhs_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .hold_i    (hold_i),
        .reg_rdata (reg_rdata)
    );

    // fl = {pll_flag, phy_flag}
    function automatic logic [9:0] mk(input logic [1:0] fl, input logic [1:0] pr,
                                      input logic [1:0] po, input logic [1:0] lr,
                                      input logic [1:0] lo);
        return {fl, pr, po, lr, lo};
    endfunction

    task automatic chk(input string req, input logic [9:0] exp);
        total++;
        if (reg_rdata !== exp) begin
            bad++;
            $display("FAIL %s: rdata=%h expected %h", req, reg_rdata, exp);
        end
    endtask

    task automatic wr(input logic [9:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        cyc(2);
        chk("R1 in reset", 10'h000);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after reset", 10'h000);
    endtask

    task automatic t_basic;
        wr(mk(2'b00, 2'b01, 2'b11, 2'b11, 2'b11));
        chk("R2/R3 request readback, status bits ignored", mk(0, 2'b01, 2'b00, 2'b11, 2'b00));
        cyc(3);
        chk("R4 PHY not before settle", mk(0, 2'b01, 2'b00, 2'b11, 2'b00));
        cyc(1);
        chk("R4 PHY settles at E+4", mk(0, 2'b01, 2'b01, 2'b11, 2'b00));
        cyc(2);
        chk("R4 PLL not before settle", mk(0, 2'b01, 2'b01, 2'b11, 2'b00));
        cyc(1);
        chk("R4 PLL settles at E+7", mk(0, 2'b01, 2'b01, 2'b11, 2'b11));
    endtask

    task automatic t_same;
        wr(mk(0, 2'b01, 2'b00, 2'b11, 2'b00));
        chk("R5 same request no change", mk(0, 2'b01, 2'b01, 2'b11, 2'b11));
        cyc(8);
        chk("R5 still unchanged", mk(0, 2'b01, 2'b01, 2'b11, 2'b11));
        wr(mk(0, 2'b10, 2'b00, 2'b11, 2'b00));
        chk("R5 pending request visible", mk(0, 2'b10, 2'b01, 2'b11, 2'b11));
        cyc(1);
        wr(mk(0, 2'b01, 2'b00, 2'b11, 2'b00));
        cyc(10);
        chk("R5 cancelled transition", mk(0, 2'b01, 2'b01, 2'b11, 2'b11));
    endtask

    task automatic t_restart;
        wr(mk(0, 2'b10, 2'b00, 2'b11, 2'b00));
        cyc(1);
        wr(mk(0, 2'b11, 2'b00, 2'b11, 2'b00));
        chk("R6 new request shown", mk(0, 2'b11, 2'b01, 2'b11, 2'b11));
        cyc(3);
        chk("R6 restarted, not yet", mk(0, 2'b11, 2'b01, 2'b11, 2'b11));
        cyc(1);
        chk("R6 settles from second write", mk(0, 2'b11, 2'b11, 2'b11, 2'b11));
    endtask

    task automatic t_norestart;
        wr(mk(0, 2'b00, 2'b00, 2'b11, 2'b00));
        chk("R7 request shown", mk(0, 2'b00, 2'b11, 2'b11, 2'b11));
        cyc(1);
        wr(mk(0, 2'b00, 2'b00, 2'b11, 2'b00));
        cyc(1);
        chk("R7 before original settle edge", mk(0, 2'b00, 2'b11, 2'b11, 2'b11));
        cyc(1);
        chk("R7 settles on original schedule", mk(0, 2'b00, 2'b00, 2'b11, 2'b11));
    endtask

    task automatic t_hold;
        hold_i = 2'b10;
        wr(mk(0, 2'b00, 2'b00, 2'b01, 2'b00));
        cyc(10);
        chk("R8 held PLL keeps mode", mk(0, 2'b00, 2'b00, 2'b01, 2'b11));
        hold_i = 2'b00;
        cyc(6);
        chk("R8 remaining settle not done", mk(0, 2'b00, 2'b00, 2'b01, 2'b11));
        cyc(1);
        chk("R8 settles after release", mk(0, 2'b00, 2'b00, 2'b01, 2'b01));
        cyc(5);
        chk("R9 no flag for settled transition", mk(0, 2'b00, 2'b00, 2'b01, 2'b01));
    endtask

    task automatic t_timeout;
        hold_i = 2'b01;
        wr(mk(0, 2'b01, 2'b00, 2'b01, 2'b00));
        cyc(19);
        chk("R9 no flag before timeout", mk(0, 2'b01, 2'b00, 2'b01, 2'b01));
        cyc(1);
        chk("R9 PHY flag at E+20", mk(2'b01, 2'b01, 2'b00, 2'b01, 2'b01));
        wr(mk(2'b00, 2'b01, 2'b00, 2'b01, 2'b00));
        chk("R10 write 0 keeps flag", mk(2'b01, 2'b01, 2'b00, 2'b01, 2'b01));
        wr(mk(2'b01, 2'b01, 2'b00, 2'b01, 2'b00));
        chk("R10 write 1 clears flag", mk(0, 2'b01, 2'b00, 2'b01, 2'b01));
        cyc(5);
        chk("R9 flag not re-raised", mk(0, 2'b01, 2'b00, 2'b01, 2'b01));
        hold_i = 2'b00;
        cyc(3);
        chk("R8 PHY still settling", mk(0, 2'b01, 2'b00, 2'b01, 2'b01));
        cyc(1);
        chk("R8 PHY settles after release", mk(0, 2'b01, 2'b01, 2'b01, 2'b01));
    endtask

    task automatic t_setwins;
        hold_i = 2'b10;
        wr(mk(0, 2'b01, 2'b00, 2'b10, 2'b00));
        cyc(19);
        chk("R9 PLL no flag yet", mk(0, 2'b01, 2'b01, 2'b10, 2'b01));
        wr(mk(2'b10, 2'b01, 2'b00, 2'b10, 2'b00));
        chk("R10 set wins over clear", mk(2'b10, 2'b01, 2'b01, 2'b10, 2'b01));
        wr(mk(2'b10, 2'b01, 2'b00, 2'b10, 2'b00));
        chk("R10 PLL flag cleared", mk(0, 2'b01, 2'b01, 2'b10, 2'b01));
        hold_i = 2'b00;
        cyc(6);
        chk("R8 PLL still settling", mk(0, 2'b01, 2'b01, 2'b10, 2'b01));
        cyc(1);
        chk("R11 PLL reaches request", mk(0, 2'b01, 2'b01, 2'b10, 2'b10));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_same();
        t_restart();
        t_norestart();
        t_hold();
        t_timeout();
        t_setwins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule